// File: doc/BRIEF.md
# Shuffled Interleaved Accumulation Scheduler

This block computes the weighted sums of every node in one fully connected binarized layer through a single adder. The adder is external, masked and pipelined, with a fixed latency of `LAT` cycles. To keep that adder busy on every cycle, the scheduler works on groups of `LAT+1` independent nodes in turn. It issues input `k` of each node in the group, one node per cycle, then comes back to the first node just as its previous partial sum returns. Partial sums are held as two Boolean shares in a small register file with one slot per group member.

Each layer run starts from a node index supplied with the start request, normally drawn at random. Nodes are taken in rotated order: from that index up to the last node, then from node 0 onward. Only the starting address changes, so the schedule and its length are the same for every start index. Products are formed inside the block. In the input layer they come from an 8-bit pixel and a weight bit; in hidden layers they come from an activation bit and a weight bit. Each product is split into shares with a fresh random word before it reaches the adder. The bias is added in one extra pass. The sign activation leaves the block as a share pair.

Top module: `shuf_accum_sched`

## Requirements
- R1: `start_i` in a cycle with `busy_o` low is accepted. `busy_o` is high from the next cycle for exactly NGRP*(N_INPUTS+1)*G + LAT cycles, where G = LAT+1 and NGRP = ceil(N_NODES/G), whatever the start index. `issue_vld_o` is never high while `busy_o` is low.
- R2: Group position p (0 to NGRP*G-1) maps to node (s + p) mod N_NODES, where s is the accepted start index. Activations leave in the order s, s+1, ..., N_NODES-1, 0, ..., s-1.
- R3: Count cycles from the start cycle as 0. Position p = g*G + j issues input k in cycle 1 + g*(N_INPUTS+1)*G + k*G + j. Here k runs from 0 to N_INPUTS-1, then k = N_INPUTS is the bias pass, and `issue_in_o` shows k.
- R4: With `mode_i` = 0 (pixel layer), the product is +pixel when `wbit_i` = 1 and -pixel when `wbit_i` = 0. The pixel is zero-extended to 9 bits, negated if needed, then sign-extended to DW bits.
- R5: With `mode_i` = 1 (binary layer), the product is +1 when `abit_i` equals `wbit_i` and -1 otherwise, in DW-bit two's complement.
- R6: On an input pass, the B shares are (product XOR `rnd_i`, `rnd_i`). On pass k = 0 both A shares are zero. On every later pass, A0 XOR A1 equals the node's running sum as returned by the adder.
- R7: On the bias pass, `bias_s0_i` and `bias_s1_i` go to B0 and B1 unchanged. The bias is read for node `issue_node_o`.
- R8: One cycle after the bias-pass result returns (LAT+1 cycles after the bias issue), `act_vld_o` pulses with the node index. `act_s0_o` is the inverted MSB of result share 0, and `act_s1_o` is the MSB of result share 1. Their XOR is 1 exactly when the final sum is non-negative, so a sum of zero gives 1.
- R9: Positions at or beyond N_NODES issue nothing, with `issue_vld_o` low. A layer makes exactly N_NODES*(N_INPUTS+1) valid issues and N_NODES activations.
- R10: `done_o` is a one-cycle pulse in cycle NGRP*(N_INPUTS+1)*G + LAT + 1 after the start cycle. `busy_o` is low in that cycle.
- R11: A start request while `busy_o` is high is ignored. The start index and mode of the running layer stay in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to run one layer |
| start_idx_i | input | NODE_W | Random first node, below N_NODES |
| mode_i | input | 1 | 0 = pixel layer, 1 = binary layer |
| busy_o | output | 1 | Layer in progress |
| issue_vld_o | output | 1 | Adder operands valid this cycle |
| issue_node_o | output | NODE_W | Node being served (weight and bias address) |
| issue_in_o | output | IN_W | Input index k, N_INPUTS on the bias pass |
| pixel_i | input | PIX_W | Unsigned pixel for input k |
| wbit_i | input | 1 | Weight bit for (node, k) |
| abit_i | input | 1 | Previous-layer activation bit for input k |
| bias_s0_i | input | DW | Bias share 0 for the node |
| bias_s1_i | input | DW | Bias share 1 for the node |
| rnd_i | input | DW | Fresh random mask for the product |
| add_a0_o | output | DW | Adder operand A, share 0 |
| add_a1_o | output | DW | Adder operand A, share 1 |
| add_b0_o | output | DW | Adder operand B, share 0 |
| add_b1_o | output | DW | Adder operand B, share 1 |
| res_s0_i | input | DW | Adder result share 0, LAT cycles after issue |
| res_s1_i | input | DW | Adder result share 1 |
| act_vld_o | output | 1 | Activation valid |
| act_node_o | output | NODE_W | Node of the activation |
| act_s0_o | output | 1 | Activation share 0 |
| act_s1_o | output | 1 | Activation share 1 |
| done_o | output | 1 | Layer complete pulse |

## Verification
Some rules are checked on every cycle by properties. Busy time must be the same for every start index. No issue may occur while idle. Consecutive issues within a pass must step to the next node modulo the node count. Each activation must be the complemented sign of the result that came back one cycle earlier. `done_o` must last a single cycle.

Other facts depend on values only the bench knows: the memory data, the random masks, and the expected sums. These are the product encodings for both layer modes, the running sums offered back as operand A, and bias passing. They also include the exact issue cycle of every (node, input) pair, the activation order from a rotated start, the zero-sum sign boundary, and the rejection of a start request in mid-layer.

// File: rtl/sas_pkg.sv
package sas_pkg;
  typedef enum logic {
    MODE_PIXEL  = 1'b0,
    MODE_BINARY = 1'b1
  } sas_mode_e;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/sas_order.sv
module sas_order import sas_pkg::*; #(
  parameter int N_NODES  = 10,
  parameter int N_INPUTS = 6,
  parameter int LAT      = 3,
  parameter int NODE_W   = 4,
  parameter int IN_W     = 3,
  parameter int SLOT_W   = 2,
  parameter int POS_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic [NODE_W-1:0] start_idx_i,
  input  logic              mode_i,
  output logic              active_o,
  output logic [NODE_W-1:0] node_o,
  output logic [IN_W-1:0]   in_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              first_o,
  output logic              bias_o,
  output logic              final_o,
  output sas_mode_e         mode_o
);
  localparam int G = LAT + 1;

  logic              run_q, run_d;
  logic [IN_W-1:0]   k_q, k_d;
  logic [SLOT_W-1:0] j_q, j_d;
  logic [POS_W-1:0]  grp_q, grp_d;
  logic [NODE_W-1:0] s_q, s_d;
  sas_mode_e         mode_q, mode_d;
  logic              en;

  logic              last_j, last_k, last_grp;
  logic [POS_W-1:0]  pos;
  logic [POS_W:0]    raw;
  logic [POS_W:0]    wrapped;

  always_comb begin
    last_j   = (j_q == SLOT_W'(G - 1));
    last_k   = (k_q == IN_W'(N_INPUTS));
    last_grp = ((int'(grp_q) + G) >= N_NODES);
    pos      = grp_q + POS_W'(j_q);
    raw      = (POS_W+1)'(s_q) + (POS_W+1)'(pos);
    wrapped  = (int'(raw) >= N_NODES) ? (raw - (POS_W+1)'(N_NODES)) : raw;
  end

  always_comb begin
    run_d  = run_q;
    k_d    = k_q;
    j_d    = j_q;
    grp_d  = grp_q;
    s_d    = s_q;
    mode_d = mode_q;
    if (!run_q) begin
      if (accept_i) begin
        run_d  = 1'b1;
        k_d    = '0;
        j_d    = '0;
        grp_d  = '0;
        s_d    = start_idx_i;
        mode_d = sas_mode_e'(mode_i);
      end
    end else begin
      j_d = last_j ? '0 : j_q + 1'b1;
      if (last_j) begin
        k_d = last_k ? '0 : k_q + 1'b1;
        if (last_k) begin
          grp_d = grp_q + POS_W'(G);
          if (last_grp) run_d = 1'b0;
        end
      end
    end
  end

  assign en = run_q | accept_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      k_q    <= '0;
      j_q    <= '0;
      grp_q  <= '0;
      s_q    <= '0;
      mode_q <= MODE_PIXEL;
    end else if (en) begin
      run_q  <= run_d;
      k_q    <= k_d;
      j_q    <= j_d;
      grp_q  <= grp_d;
      s_q    <= s_d;
      mode_q <= mode_d;
    end
  end

  assign active_o = run_q && (int'(pos) < N_NODES);
  assign node_o   = NODE_W'(wrapped);
  assign in_o     = k_q;
  assign slot_o   = j_q;
  assign first_o  = (k_q == '0);
  assign bias_o   = last_k;
  assign final_o  = run_q && last_j && last_k && last_grp;
  assign mode_o   = mode_q;
endmodule

// File: rtl/sas_operand.sv
module sas_operand import sas_pkg::*; #(
  parameter int DW    = 12,
  parameter int PIX_W = 8
) (
  input  logic             active_i,
  input  logic             first_i,
  input  logic             bias_i,
  input  sas_mode_e        mode_i,
  input  logic [PIX_W-1:0] pixel_i,
  input  logic             wbit_i,
  input  logic             abit_i,
  input  logic [DW-1:0]    bias_s0_i,
  input  logic [DW-1:0]    bias_s1_i,
  input  logic [DW-1:0]    rnd_i,
  input  logic [DW-1:0]    rf_s0_i,
  input  logic [DW-1:0]    rf_s1_i,
  output logic [DW-1:0]    a0_o,
  output logic [DW-1:0]    a1_o,
  output logic [DW-1:0]    b0_o,
  output logic [DW-1:0]    b1_o
);
  logic [PIX_W:0]  mag9;
  logic [PIX_W:0]  signed9;
  logic [DW-1:0]   prod;

  always_comb begin
    mag9    = {1'b0, pixel_i};
    signed9 = wbit_i ? mag9 : (~mag9 + 1'b1);
    if (mode_i == MODE_BINARY) begin
      prod = (abit_i ~^ wbit_i) ? DW'(1) : '1;
    end else begin
      prod = {{(DW-PIX_W-1){signed9[PIX_W]}}, signed9};
    end
  end

  always_comb begin
    a0_o = '0;
    a1_o = '0;
    b0_o = '0;
    b1_o = '0;
    if (active_i) begin
      if (!first_i) begin
        a0_o = rf_s0_i;
        a1_o = rf_s1_i;
      end
      if (bias_i) begin
        b0_o = bias_s0_i;
        b1_o = bias_s1_i;
      end else begin
        b0_o = prod ^ rnd_i;
        b1_o = rnd_i;
      end
    end
  end
endmodule

// File: rtl/sas_tagpipe.sv
module sas_tagpipe #(
  parameter int LAT = 3,
  parameter int TW  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] tag_i,
  output logic [TW-1:0] tag_o
);
  logic [TW-1:0] stage [LAT];

  for (genvar i = 0; i < LAT; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[i] <= '0;
        else        stage[i] <= tag_i;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[i] <= '0;
        else        stage[i] <= stage[i-1];
      end
    end
  end

  assign tag_o = stage[LAT-1];
endmodule

// File: rtl/sas_psum.sv
module sas_psum #(
  parameter int G      = 4,
  parameter int DW     = 12,
  parameter int SLOT_W = 2,
  parameter int NODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic [DW-1:0]     rd_s0_o,
  output logic [DW-1:0]     rd_s1_o,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [DW-1:0]     res_s0_i,
  input  logic [DW-1:0]     res_s1_i,
  input  logic              cap_en_i,
  input  logic [NODE_W-1:0] cap_node_i,
  input  logic              final_i,
  output logic              act_vld_o,
  output logic [NODE_W-1:0] act_node_o,
  output logic              act_s0_o,
  output logic              act_s1_o,
  output logic              done_o
);
  logic [DW-1:0] sh0 [G];
  logic [DW-1:0] sh1 [G];

  for (genvar e = 0; e < G; e++) begin : g_slot
    logic wr_hit;
    assign wr_hit = wr_en_i && (wr_slot_i == SLOT_W'(e));
    always_ff @(posedge clk) begin
      if (wr_hit) begin
        sh0[e] <= res_s0_i;
        sh1[e] <= res_s1_i;
      end
    end
  end

  assign rd_s0_o = sh0[rd_slot_i];
  assign rd_s1_o = sh1[rd_slot_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_vld_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      act_vld_o <= cap_en_i;
      done_o    <= final_i;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en_i) begin
      act_node_o <= cap_node_i;
      act_s0_o   <= ~res_s0_i[DW-1];
      act_s1_o   <= res_s1_i[DW-1];
    end
  end
endmodule

// File: rtl/shuf_accum_sched.sv
module shuf_accum_sched import sas_pkg::*; #(
  parameter int  N_NODES  = 10,
  parameter int  N_INPUTS = 6,
  parameter int  LAT      = 3,
  parameter int  DW       = 12,
  parameter int  PIX_W    = 8,
  localparam int NODE_W   = $clog2(N_NODES),
  localparam int IN_W     = $clog2(N_INPUTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [NODE_W-1:0] start_idx_i,
  input  logic              mode_i,
  output logic              busy_o,
  output logic              issue_vld_o,
  output logic [NODE_W-1:0] issue_node_o,
  output logic [IN_W-1:0]   issue_in_o,
  input  logic [PIX_W-1:0]  pixel_i,
  input  logic              wbit_i,
  input  logic              abit_i,
  input  logic [DW-1:0]     bias_s0_i,
  input  logic [DW-1:0]     bias_s1_i,
  input  logic [DW-1:0]     rnd_i,
  output logic [DW-1:0]     add_a0_o,
  output logic [DW-1:0]     add_a1_o,
  output logic [DW-1:0]     add_b0_o,
  output logic [DW-1:0]     add_b1_o,
  input  logic [DW-1:0]     res_s0_i,
  input  logic [DW-1:0]     res_s1_i,
  output logic              act_vld_o,
  output logic [NODE_W-1:0] act_node_o,
  output logic              act_s0_o,
  output logic              act_s1_o,
  output logic              done_o
);
  localparam int G      = LAT + 1;
  localparam int NGRP   = ceil_div(N_NODES, G);
  localparam int SPAN   = NGRP * G;
  localparam int POS_W  = $clog2(SPAN + 1);
  localparam int SLOT_W = $clog2(G);
  localparam int TW     = 3 + NODE_W + SLOT_W;

  logic              accept;
  logic              busy_q, busy_d;
  logic              active, first, bias, fin;
  logic [SLOT_W-1:0] slot;
  sas_mode_e         mode;
  logic [DW-1:0]     rf_s0, rf_s1;
  logic [TW-1:0]     tag_in, tag_out;
  logic              t_vld, t_fin, t_bias;
  logic [NODE_W-1:0] t_node;
  logic [SLOT_W-1:0] t_slot;

  assign accept = start_i && !busy_q;

  u_order_inst: begin end

  sas_order #(
    .N_NODES(N_NODES), .N_INPUTS(N_INPUTS), .LAT(LAT),
    .NODE_W(NODE_W), .IN_W(IN_W), .SLOT_W(SLOT_W), .POS_W(POS_W)
  ) u_order (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .start_idx_i(start_idx_i),
    .mode_i(mode_i), .active_o(active), .node_o(issue_node_o),
    .in_o(issue_in_o), .slot_o(slot), .first_o(first), .bias_o(bias),
    .final_o(fin), .mode_o(mode)
  );

  sas_operand #(.DW(DW), .PIX_W(PIX_W)) u_operand (
    .active_i(active), .first_i(first), .bias_i(bias), .mode_i(mode),
    .pixel_i(pixel_i), .wbit_i(wbit_i), .abit_i(abit_i),
    .bias_s0_i(bias_s0_i), .bias_s1_i(bias_s1_i), .rnd_i(rnd_i),
    .rf_s0_i(rf_s0), .rf_s1_i(rf_s1),
    .a0_o(add_a0_o), .a1_o(add_a1_o), .b0_o(add_b0_o), .b1_o(add_b1_o)
  );

  assign tag_in = {active, fin, bias, issue_node_o, slot};

  sas_tagpipe #(.LAT(LAT), .TW(TW)) u_tags (
    .clk(clk), .rst_n(rst_n), .tag_i(tag_in), .tag_o(tag_out)
  );

  assign {t_vld, t_fin, t_bias, t_node, t_slot} = tag_out;

  sas_psum #(.G(G), .DW(DW), .SLOT_W(SLOT_W), .NODE_W(NODE_W)) u_psum (
    .clk(clk), .rst_n(rst_n), .rd_slot_i(slot), .rd_s0_o(rf_s0), .rd_s1_o(rf_s1),
    .wr_en_i(t_vld && !t_bias), .wr_slot_i(t_slot),
    .res_s0_i(res_s0_i), .res_s1_i(res_s1_i),
    .cap_en_i(t_vld && t_bias), .cap_node_i(t_node), .final_i(t_fin),
    .act_vld_o(act_vld_o), .act_node_o(act_node_o),
    .act_s0_o(act_s0_o), .act_s1_o(act_s1_o), .done_o(done_o)
  );

  always_comb begin
    busy_d = busy_q;
    if (accept)     busy_d = 1'b1;
    else if (t_fin) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  assign busy_o      = busy_q;
  assign issue_vld_o = active;
endmodule

// File: rtl/shuf_accum_sched_chk.sv
module shuf_accum_sched_chk #(
  parameter int N_NODES  = 10,
  parameter int N_INPUTS = 6,
  parameter int LAT      = 3,
  parameter int NODE_W   = 4,
  parameter int IN_W     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              issue_vld_o,
  input logic [NODE_W-1:0] issue_node_o,
  input logic [IN_W-1:0]   issue_in_o,
  input logic              res_msb0,
  input logic              res_msb1,
  input logic              act_vld_o,
  input logic              act_s0_o,
  input logic              act_s1_o,
  input logic              done_o
);
  localparam int G        = LAT + 1;
  localparam int NGRP     = (N_NODES + G - 1) / G;
  localparam int BUSY_CYC = NGRP * (N_INPUTS + 1) * G + LAT;

  int busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_cnt <= 0;
    else if (busy_o) busy_cnt <= busy_cnt + 1;
    else             busy_cnt <= 0;
  end

  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !issue_vld_o);

  assert_const_time_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (busy_cnt == BUSY_CYC));

  assert_node_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld_o |-> (int'(issue_node_o) < N_NODES));

  assert_rotate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld_o && $past(issue_vld_o) && (issue_in_o == $past(issue_in_o)))
      |-> (int'(issue_node_o) == ((int'($past(issue_node_o)) + 1) % N_NODES)));

  assert_act_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
    act_vld_o |-> ((act_s0_o ^ act_s1_o) == !($past(res_msb0) ^ $past(res_msb1))));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

bind shuf_accum_sched shuf_accum_sched_chk #(
  .N_NODES(N_NODES), .N_INPUTS(N_INPUTS), .LAT(LAT),
  .NODE_W(NODE_W), .IN_W(IN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .issue_vld_o(issue_vld_o), .issue_node_o(issue_node_o), .issue_in_o(issue_in_o),
  .res_msb0(res_s0_i[DW-1]), .res_msb1(res_s1_i[DW-1]),
  .act_vld_o(act_vld_o), .act_s0_o(act_s0_o), .act_s1_o(act_s1_o),
  .done_o(done_o)
);

// File: tb/tb_shuf_accum_sched.sv
module tb_shuf_accum_sched;
  localparam int N      = 10;
  localparam int NI     = 6;
  localparam int LAT    = 3;
  localparam int DW     = 12;
  localparam int G      = LAT + 1;
  localparam int NGRP   = (N + G - 1) / G;
  localparam int T      = NGRP * (NI + 1) * G;
  localparam int NODE_W = $clog2(N);
  localparam int IN_W   = $clog2(NI + 1);

  logic              clk, rst_n;
  logic              start_i, mode_i;
  logic [NODE_W-1:0] start_idx_i;
  logic              busy_o, issue_vld_o;
  logic [NODE_W-1:0] issue_node_o, act_node_o;
  logic [IN_W-1:0]   issue_in_o;
  logic [7:0]        pixel_i;
  logic              wbit_i, abit_i;
  logic [DW-1:0]     bias_s0_i, bias_s1_i, rnd_i;
  logic [DW-1:0]     add_a0_o, add_a1_o, add_b0_o, add_b1_o;
  logic [DW-1:0]     res_s0_i, res_s1_i;
  logic              act_vld_o, act_s0_o, act_s1_o, done_o;

  int checks = 0;
  int errors = 0;
  int seed   = 0;
  int tcase  = 0;
  int wd     = 0;
  logic [15:0] lf = 16'hACE1;
  logic [15:0] lf2 = 16'h5A5A;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] pix_f(input int k);
    return 8'((k * 53 + seed * 29 + 17) & 255);
  endfunction
  function automatic logic wb_f(input int n, input int k);
    if (tcase == 1) return 1'b1;
    return ((n * 5 + k * 3 + seed) % 7) < 3;
  endfunction
  function automatic logic ab_f(input int k);
    if (tcase == 1) return 1'b1;
    return 1'((k + seed) & 1);
  endfunction
  function automatic logic [DW-1:0] bias_f(input int n);
    if (tcase == 1) return (n % 2 == 0) ? DW'(-NI) : DW'(-NI - 1);
    return DW'(((n * 13 + seed) % 61) - 30);
  endfunction
  function automatic logic [DW-1:0] bmask_f(input int n);
    return DW'(n * 97 + seed * 3);
  endfunction
  function automatic logic [DW-1:0] prod_f(input logic md, input int n, input int k);
    if (md) return (ab_f(k) == wb_f(n, k)) ? DW'(1) : DW'(-1);
    return wb_f(n, k) ? DW'(int'(pix_f(k))) : DW'(-int'(pix_f(k)));
  endfunction

  assign pixel_i   = pix_f(int'(issue_in_o));
  assign wbit_i    = wb_f(int'(issue_node_o), int'(issue_in_o));
  assign abit_i    = ab_f(int'(issue_in_o));
  assign bias_s1_i = bmask_f(int'(issue_node_o));
  assign bias_s0_i = bias_f(int'(issue_node_o)) ^ bmask_f(int'(issue_node_o));

  logic [DW-1:0] pa [LAT];
  logic [DW-1:0] pb [LAT];
  logic [DW-1:0] pm [LAT];
  always @(posedge clk) begin
    lf2   <= {lf2[14:0], lf2[15] ^ lf2[13] ^ lf2[12] ^ lf2[10]};
    pa[0] <= add_a0_o ^ add_a1_o;
    pb[0] <= add_b0_o ^ add_b1_o;
    pm[0] <= lf2[DW-1:0];
    for (int i = 1; i < LAT; i++) begin
      pa[i] <= pa[i-1];
      pb[i] <= pb[i-1];
      pm[i] <= pm[i-1];
    end
  end
  assign res_s0_i = (pa[LAT-1] + pb[LAT-1]) ^ pm[LAT-1];
  assign res_s1_i = pm[LAT-1];

  shuf_accum_sched #(.N_NODES(N), .N_INPUTS(NI), .LAT(LAT), .DW(DW), .PIX_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_idx_i(start_idx_i),
    .mode_i(mode_i), .busy_o(busy_o), .issue_vld_o(issue_vld_o),
    .issue_node_o(issue_node_o), .issue_in_o(issue_in_o),
    .pixel_i(pixel_i), .wbit_i(wbit_i), .abit_i(abit_i),
    .bias_s0_i(bias_s0_i), .bias_s1_i(bias_s1_i), .rnd_i(rnd_i),
    .add_a0_o(add_a0_o), .add_a1_o(add_a1_o), .add_b0_o(add_b0_o), .add_b1_o(add_b1_o),
    .res_s0_i(res_s0_i), .res_s1_i(res_s1_i),
    .act_vld_o(act_vld_o), .act_node_o(act_node_o),
    .act_s0_o(act_s0_o), .act_s1_o(act_s1_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", wd, 20000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step_rnd();
    lf    = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    rnd_i = lf[DW-1:0];
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_i = 1'b0; start_idx_i = '0; mode_i = 1'b0; rnd_i = '0;
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R1 busy in reset", busy_o, 0);
    chk(issue_vld_o == 1'b0, "R1 issue in reset", issue_vld_o, 0);
    chk(act_vld_o == 1'b0, "R8 act in reset", act_vld_o, 0);
    chk(done_o == 1'b0, "R10 done in reset", done_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0 && issue_vld_o == 1'b0, "R1 idle after reset", busy_o, 0);
  endtask

  // One layer run; ext_at > 0 fires an extra start (R11) in that cycle
  task automatic run_layer(input int s, input logic md, input int ext_at);
    logic [DW-1:0] ps [N];
    logic [DW-1:0] bexp;
    int cyc, nbusy, nvld, nact, done_cyc, n, k, p, g, j, ec;
    for (int i = 0; i < N; i++) ps[i] = '0;
    nbusy = 0; nvld = 0; nact = 0; done_cyc = -1; cyc = 0;
    @(negedge clk);
    start_i = 1'b1; start_idx_i = NODE_W'(s); mode_i = md;
    while (cyc < T + LAT + 20 && done_cyc < 0) begin
      @(negedge clk);
      cyc++;
      start_i = 1'b0;
      if (cyc == ext_at) begin
        start_i = 1'b1; start_idx_i = NODE_W'((s + 3) % N); mode_i = ~md;
      end
      step_rnd();
      #1;
      if (busy_o) nbusy++;
      if (issue_vld_o) begin
        n = int'(issue_node_o); k = int'(issue_in_o);
        nvld++;
        if (n < N && k <= NI) begin
          p  = (n - s + N) % N; g = p / G; j = p % G;
          ec = 1 + g * (NI + 1) * G + k * G + j;
          chk(cyc == ec, "R3 issue cycle", cyc, ec);
          if (k == 0) chk(add_a0_o == '0 && add_a1_o == '0, "R6 zero first pass", add_a0_o, 0);
          else chk((add_a0_o ^ add_a1_o) == ps[n], "R6 running sum", add_a0_o ^ add_a1_o, ps[n]);
          if (k == NI) begin
            bexp = bias_f(n);
            chk(add_b0_o == (bexp ^ bmask_f(n)) && add_b1_o == bmask_f(n), "R7 bias pass",
                add_b0_o ^ add_b1_o, bexp);
          end else begin
            bexp = prod_f(md, n, k);
            chk((add_b0_o ^ add_b1_o) == bexp, md ? "R5 binary product" : "R4 pixel product",
                add_b0_o ^ add_b1_o, bexp);
            chk(add_b1_o == rnd_i, "R6 product mask", add_b1_o, rnd_i);
          end
          ps[n] = ps[n] + bexp;
        end else begin
          chk(1'b0, "R2 issue index range", n, k);
        end
      end
      if (act_vld_o) begin
        n = int'(act_node_o);
        chk(n == (s + nact) % N, "R2 activation order", n, (s + nact) % N);
        if (n < N) begin
          p  = (n - s + N) % N; g = p / G; j = p % G;
          ec = 1 + g * (NI + 1) * G + NI * G + j + LAT + 1;
          chk(cyc == ec, "R8 activation cycle", cyc, ec);
          chk((act_s0_o ^ act_s1_o) == ~ps[n][DW-1], "R8 activation value",
              act_s0_o ^ act_s1_o, ~ps[n][DW-1]);
        end
        nact++;
      end
      if (done_o) done_cyc = cyc;
    end
    chk(done_cyc == T + LAT + 1, "R10 done cycle", done_cyc, T + LAT + 1);
    chk(nbusy == T + LAT, "R1 busy length", nbusy, T + LAT);
    chk(nvld == N * (NI + 1), "R9 valid issues", nvld, N * (NI + 1));
    chk(nact == N, "R9 activation count", nact, N);
    @(negedge clk);
    chk(done_o == 1'b0, "R10 single pulse", done_o, 0);
    chk(busy_o == 1'b0, "R11 no late start", busy_o, 0);
  endtask

  task automatic t_pixel_s0();
    seed = 1; tcase = 0; run_layer(0, 1'b0, 0);
  endtask
  task automatic t_pixel_wrap();
    seed = 4; tcase = 0; run_layer(7, 1'b0, 0);
  endtask
  task automatic t_binary_last();
    seed = 9; tcase = 0; run_layer(N - 1, 1'b1, 0);
  endtask
  task automatic t_sign_boundary();
    seed = 2; tcase = 1; run_layer(2, 1'b1, 0);
  endtask
  task automatic t_start_busy();
    seed = 6; tcase = 0; run_layer(4, 1'b0, 5);
  endtask

  initial begin
    t_reset();
    t_pixel_s0();
    t_pixel_wrap();
    t_binary_last();
    t_sign_boundary();
    t_start_busy();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule